// File: doc/BRIEF.md
# Card Command Sequencer with Response Capture

This block runs a single command exchange with a memory card. Software-side writes load a 6-bit command index, a 32-bit argument (as two independent 16-bit halves) and a command configuration word. The configuration word holds the response type, the data-phase enable, the direction, the DMA enable and a stop-transfer bit. A configuration write marks a command as pending. The command goes out once that request, an enabled card clock and a clear stop-transfer bit are all present. It does not matter whether the clock start or the configuration write comes first.

The command index and argument are driven onto a request/response port. The request is held until the card side answers with a byte count and up to 16 response bytes. The block compares the byte count with the minimum that the configured response type needs. On a short answer it flags a response timeout. Otherwise it packs the bytes, two per 16-bit entry, into a nine-entry response buffer, which is then drained by successive reads. It then either returns to idle or pulses a start to the data engine, together with the direction and DMA settings.

Top module: `sd_cmd_seq`

## Requirements
- R1: A configuration write (write select 1) stores `wr_data & 16'h3DFF` and reads back on read select 1. It marks a command pending. While a command is waiting for its response, writes to the configuration, index and argument registers are ignored.
- R2: Index writes (select 2) keep bits 5:0, and read select 2 returns the index ORed with `16'h0040`. Select 3 writes and reads argument bits 31:16, and select 4 writes and reads bits 15:0. Each half-write leaves the other half unchanged.
- R3: A command launches (`card_req` rises) only when it is pending, the clock is enabled and configuration bit 10 (stop-transfer) is clear. Both orders of clock start and configuration write lead to a launch.
- R4: At launch, `card_req` holds `card_cmd` and `card_arg` steady until `card_rsp_valid`. `fifo_flush` pulses for one cycle, the end-of-command interrupt `irq_end_cmd` sets, and the timeout and done status bits clear.
- R5: The response type is configuration bits 1:0. Type 0 always succeeds. Types 1 and 3 need `card_rsp_len` of at least 4, and type 2 needs at least 16. A shorter answer sets status bit 1 (timeout) and returns to idle with the response buffer all zero.
- R6: On success, entry i holds response byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Bytes at or beyond `card_rsp_len` read as zero, and so does entry 8.
- R7: Each read with select 5 returns the next response entry, starting from entry 0 after a success. After nine reads it returns zero.
- R8: On success, status bit 13 sets. If configuration bit 2 is set, `data_start` pulses in the cycle after the response, and `data_write` shows bit 3 and `data_dma` shows bit 7. Otherwise no start pulse is given and the block is idle.
- R9: A clock-control write (select 0) with bit 1 set sets status bit 8. One with bit 0 set clears status bit 8 and abandons a waiting command. A later response is then ignored.
- R10: `irq_end_cmd` reads on select 7 bit 0. A write of 1 to bit 0 of select 7 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe (pops the response buffer on select 5) |
| rd_sel | input | 3 | Register read select |
| rd_data | output | 16 | Register read data, combinational |
| card_req | output | 1 | Command outstanding on the card port |
| card_cmd | output | 6 | Command index to the card |
| card_arg | output | 32 | Command argument to the card |
| card_rsp_valid | input | 1 | Card response present |
| card_rsp_len | input | 5 | Number of response bytes returned |
| card_rsp_bytes | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| fifo_flush | output | 1 | One-cycle pulse emptying the data FIFOs at launch |
| data_start | output | 1 | One-cycle pulse starting the data engine |
| data_write | output | 1 | Data direction, 1 = write to card |
| data_dma | output | 1 | DMA enable for the data phase |
| irq_end_cmd | output | 1 | Sticky end-of-command interrupt request |

## Verification
The hardest situations to reach are the ones that depend on when something happens while a command is outstanding. One is a clock stop arriving between launch and response, after which a late response must leave the status untouched. Another is a configuration write landing during the wait, which must be dropped. The bench reaches these by holding back its card responder and issuing those writes while `card_req` is high. It also varies the order of clock start and configuration write. It sweeps response lengths on both sides of each type's threshold, first directed and then random.

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq #(
  parameter int ENTRIES = 9,
  parameter int RSP_BYTES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [15:0]  wr_data,
  input  logic         rd_en,
  input  logic [2:0]   rd_sel,
  output logic [15:0]  rd_data,
  output logic         card_req,
  output logic [5:0]   card_cmd,
  output logic [31:0]  card_arg,
  input  logic         card_rsp_valid,
  input  logic [4:0]   card_rsp_len,
  input  logic [127:0] card_rsp_bytes,
  output logic         fifo_flush,
  output logic         data_start,
  output logic         data_write,
  output logic         data_dma,
  output logic         irq_end_cmd
);
  localparam int PW = $clog2(ENTRIES + 1);
  localparam logic [PW-1:0] PTR_END = PW'(ENTRIES);

  localparam logic [2:0] SEL_CLK = 3'd0, SEL_CFG = 3'd1, SEL_CMD = 3'd2,
                         SEL_ARGH = 3'd3, SEL_ARGL = 3'd4, SEL_RSP = 3'd5,
                         SEL_IRQ = 3'd7;
  localparam logic [2:0] SEL_STAT = 3'd0;

  typedef enum logic {S_IDLE, S_WAIT} state_t;
  state_t state;

  logic [13:0]   cfg;
  logic [5:0]    cmd_idx;
  logic [31:0]   arg;
  logic          pending, clk_on, st_tout, st_done, irq;
  logic [15:0]   rsp_q [ENTRIES];
  logic [15:0]   packed_e [ENTRIES];
  logic [PW-1:0] rd_ptr;
  logic          len_ok;

  wire busy    = (state == S_WAIT);
  wire stop_wr = wr_en && wr_sel == SEL_CLK && wr_data[0];
  wire launch  = !busy && pending && clk_on && !cfg[10] && !wr_en;
  wire rsp_in  = busy && card_rsp_valid && !stop_wr;

  always_comb begin
    case (cfg[1:0])
      2'd0:    len_ok = 1'b1;
      2'd2:    len_ok = card_rsp_len >= 5'd16;
      default: len_ok = card_rsp_len >= 5'd4;
    endcase
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_pack
    localparam int LO = 2 * i;
    localparam int HI = 2 * i + 1;
    if (HI < RSP_BYTES) begin : g_live
      assign packed_e[i] = {(5'(HI) < card_rsp_len) ? card_rsp_bytes[8*HI +: 8] : 8'h00,
                            (5'(LO) < card_rsp_len) ? card_rsp_bytes[8*LO +: 8] : 8'h00};
    end else begin : g_pad
      assign packed_e[i] = 16'h0000;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cfg        <= '0;
      cmd_idx    <= '0;
      arg        <= '0;
      pending    <= 1'b0;
      clk_on     <= 1'b0;
      st_tout    <= 1'b0;
      st_done    <= 1'b0;
      irq        <= 1'b0;
      rd_ptr     <= PTR_END;
      fifo_flush <= 1'b0;
      data_start <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) rsp_q[i] <= '0;
    end else begin
      fifo_flush <= 1'b0;
      data_start <= 1'b0;
      if (rd_en && rd_sel == SEL_RSP && rd_ptr < PTR_END) rd_ptr <= rd_ptr + 1'b1;
      if (wr_en) begin
        case (wr_sel)
          SEL_CLK: begin
            if (wr_data[1]) clk_on <= 1'b1;
            if (wr_data[0]) begin
              clk_on <= 1'b0;
              state  <= S_IDLE;
            end
          end
          SEL_CFG:  if (!busy) begin
                      cfg     <= wr_data[13:0] & 14'h3DFF;
                      pending <= 1'b1;
                    end
          SEL_CMD:  if (!busy) cmd_idx <= wr_data[5:0];
          SEL_ARGH: if (!busy) arg[31:16] <= wr_data;
          SEL_ARGL: if (!busy) arg[15:0] <= wr_data;
          SEL_IRQ:  if (wr_data[0]) irq <= 1'b0;
          default: ;
        endcase
      end
      if (launch) begin
        state      <= S_WAIT;
        pending    <= 1'b0;
        fifo_flush <= 1'b1;
        irq        <= 1'b1;
        st_tout    <= 1'b0;
        st_done    <= 1'b0;
        for (int i = 0; i < ENTRIES; i++) rsp_q[i] <= '0;
      end else if (rsp_in) begin
        state <= S_IDLE;
        if (len_ok) begin
          for (int i = 0; i < ENTRIES; i++) rsp_q[i] <= packed_e[i];
          rd_ptr     <= '0;
          st_done    <= 1'b1;
          data_start <= cfg[2];
        end else begin
          st_tout <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_STAT: rd_data = {2'b00, st_done, 4'b0000, clk_on, 6'b000000, st_tout, 1'b0};
      SEL_CFG:  rd_data = {2'b00, cfg};
      SEL_CMD:  rd_data = {10'd0, cmd_idx} | 16'h0040;
      SEL_ARGH: rd_data = arg[31:16];
      SEL_ARGL: rd_data = arg[15:0];
      SEL_RSP:  rd_data = (rd_ptr < PTR_END) ? rsp_q[rd_ptr[PW-1:0]] : 16'h0000;
      SEL_IRQ:  rd_data = {15'd0, irq};
      default:  rd_data = 16'h0000;
    endcase
  end

  assign card_req    = busy;
  assign card_cmd    = cmd_idx;
  assign card_arg    = arg;
  assign data_write  = cfg[3];
  assign data_dma    = cfg[7];
  assign irq_end_cmd = irq;
endmodule

// File: rtl/sd_cmd_seq_chk.sv
module sd_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        card_req,
  input logic [5:0]  card_cmd,
  input logic [31:0] card_arg,
  input logic        fifo_flush,
  input logic        data_start,
  input logic        irq_end_cmd,
  input logic        clk_on,
  input logic        st_tout,
  input logic        st_done
);
  assert_args_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (card_req && $past(card_req)) |-> ($stable(card_cmd) && $stable(card_arg)));

  assert_flush_at_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (card_req && irq_end_cmd));

  assert_issue_needs_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_req) |-> clk_on);

  assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_tout && st_done));

  assert_start_after_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> (st_done && !card_req));

  assert_no_req_without_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |-> !card_req);
endmodule

bind sd_cmd_seq sd_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .card_req(card_req), .card_cmd(card_cmd),
  .card_arg(card_arg), .fifo_flush(fifo_flush), .data_start(data_start),
  .irq_end_cmd(irq_end_cmd), .clk_on(clk_on), .st_tout(st_tout), .st_done(st_done)
);

// File: tb/sd_cmd_seq_bench.sv
`timescale 1ns/1ps
module sd_cmd_seq_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic card_req, card_rsp_valid = 0;
  logic [5:0] card_cmd;
  logic [31:0] card_arg;
  logic [4:0] card_rsp_len = 0;
  logic [127:0] card_rsp_bytes = 0;
  logic fifo_flush, data_start, data_write, data_dma, irq_end_cmd;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_cmd_seq u_sd_cmd_seq (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] v);
    @(negedge clk); rd_en = 1; rd_sel = s; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic bit exp_ok(input logic [1:0] t, input logic [4:0] len);
    if (t == 2'd0) return 1;
    if (t == 2'd2) return len >= 16;
    return len >= 4;
  endfunction

  function automatic logic [15:0] exp_entry(input int i, input logic [4:0] len,
                                            input logic [127:0] by, input bit ok);
    logic [15:0] e = 16'h0;
    if (!ok) return e;
    for (int k = 0; k < 2; k++) begin
      int b = 2 * i + k;
      if (b < 16 && b < int'(len)) e[8*k +: 8] = by[8*b +: 8];
    end
    return e;
  endfunction

  task automatic wait_req(input string tag);
    int n = 0;
    while (!card_req && n < 20) begin @(negedge clk); n++; end
    chk({tag, " R3 launch seen"}, card_req, 1);
  endtask

  task automatic do_cmd(input logic [15:0] cfgv, input logic [5:0] idx,
                        input logic [31:0] av, input logic [4:0] len,
                        input logic [127:0] by, input bit clk_first);
    logic [15:0] v;
    bit ok = exp_ok(cfgv[1:0], len);
    if (clk_first) begin
      wr(3'd0, 16'h0002);
      wr(3'd3, av[31:16]); wr(3'd4, av[15:0]); wr(3'd2, {10'd0, idx});
      wr(3'd1, cfgv);
    end else begin
      wr(3'd0, 16'h0001);
      wr(3'd3, av[31:16]); wr(3'd4, av[15:0]); wr(3'd2, {10'd0, idx});
      wr(3'd1, cfgv);
      repeat (3) @(negedge clk);
      chk("R3 no launch with clock off", card_req, 0);
      wr(3'd0, 16'h0002);
    end
    wait_req("cmd");
    chk("R4 flush pulse", fifo_flush, 1);
    chk("R4 irq set", irq_end_cmd, 1);
    chk("R4 cmd", card_cmd, idx);
    chk("R4 arg", card_arg, av);
    card_rsp_len = len; card_rsp_bytes = by; card_rsp_valid = 1;
    @(negedge clk); card_rsp_valid = 0;
    chk("R8 data_start", data_start, ok && cfgv[2]);
    chk("R8 req dropped", card_req, 0);
    if (ok && cfgv[2]) begin
      chk("R8 dir", data_write, cfgv[3]);
      chk("R8 dma", data_dma, cfgv[7]);
    end
    rd(3'd0, v);
    chk("R5 status", v, ok ? 16'h2100 : 16'h0102);
    for (int i = 0; i < 10; i++) begin
      rd(3'd5, v);
      chk(i == 9 ? "R7 past end" : "R6 entry", v, i < 9 ? exp_entry(i, len, by, ok) : 16'h0);
    end
    wr(3'd7, 16'h0001);
    rd(3'd7, v);
    chk("R10 irq cleared", v, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset card_req", card_req, 0);
    rd(3'd0, v); chk("reset status", v, 0);
    rd(3'd1, v); chk("R1 reset cfg", v, 0);
    rd(3'd2, v); chk("R2 reset cmd", v, 16'h0040);
    rd(3'd5, v); chk("R7 reset rsp", v, 0);
    rd(3'd7, v); chk("R10 reset irq", v, 0);

    wr(3'd2, 16'hFFFF); rd(3'd2, v); chk("R2 cmd mask", v, 16'h007F);
    wr(3'd3, 16'h1234); wr(3'd4, 16'hABCD); wr(3'd3, 16'h5678);
    rd(3'd3, v); chk("R2 arg high", v, 16'h5678);
    rd(3'd4, v); chk("R2 arg low", v, 16'hABCD);

    wr(3'd0, 16'h0002);
    rd(3'd0, v); chk("R9 clock on", v, 16'h0100);
    wr(3'd1, 16'hFFFF);
    rd(3'd1, v); chk("R1 cfg mask", v, 16'h3DFF);
    repeat (4) @(negedge clk);
    chk("R3 stop-transfer holds", card_req, 0);

    do_cmd(16'h0002, 6'd2, 32'h0, 5'd15, {4{32'hA5A55A5A}}, 1);
    do_cmd(16'h0002, 6'd2, 32'h0, 5'd16, {32'h0F0E0D0C, 32'h0B0A0908, 32'h07060504, 32'h03020100}, 0);
    do_cmd(16'h0001, 6'd17, 32'hDEADBEEF, 5'd3, {4{32'h11223344}}, 1);
    do_cmd(16'h0003, 6'd41, 32'h00FF0000, 5'd4, {4{32'h99887766}}, 1);
    do_cmd(16'h0000, 6'd0, 32'h0, 5'd0, 128'h0, 0);
    do_cmd(16'h008D, 6'd24, 32'h00001000, 5'd6, {4{32'hC0FFEE00}}, 1);

    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0001);
    wait_req("abort");
    wr(3'd1, 16'h0003);
    rd(3'd1, v); chk("R1 busy cfg ignored", v, 16'h0001);
    wr(3'd0, 16'h0001);
    chk("R9 stop abandons", card_req, 0);
    card_rsp_len = 5'd4; card_rsp_valid = 1;
    @(negedge clk); card_rsp_valid = 0;
    rd(3'd0, v); chk("R9 late response ignored", v, 0);

    for (int n = 0; n < 30; n++) begin
      logic [15:0] c = 16'($urandom) & 16'h39FF;
      do_cmd(c, 6'($urandom), $urandom, 5'($urandom_range(0, 16)),
             {$urandom, $urandom, $urandom, $urandom}, 1'($urandom));
    end
    finish_run();
  end
endmodule